// File: doc/BRIEF.md
# Two-State Four-Branch Parallel Turbo Encoder

This block encodes fixed-length frames of information bits with four parallel two-state constituent encoders. The branches run, in order, a recursive accumulator, a second accumulator, a feed-forward encoder, and a third accumulator. Branch 1 reads the frame in natural order. Branches 2 to 4 each read it through their own fixed permutation. The combined code has rate 1/4 and carries no systematic bits. The block punctures it to rate 1/2, so it emits two parity bits per information bit.

Bits arrive one per cycle on a serial input that has a valid strobe and a frame-start strobe. Each completed frame is held in a ping-pong frame store, so the next frame can be collected while the current one is encoded. The same store also acts as the alignment delay: all four branches see bit index j in the same cycle, and their parity bits leave in step. The permutations come from a small arithmetic address table with a fixed test pattern. `FRAME_LEN` must be a power of two.

Top module: `mtc_encoder`

## Requirements
- R1: During and after reset, `out_valid`, `out_eof` and `out_pair` are 0. The first output cycle after reset release is also idle.
- R2: Branch 1 is an accumulator fed by frame bit d[j] in natural order. Its parity is p1[j] = d[j] XOR p1[j-1], with p1[-1] = 0.
- R3: Branch 2 is an accumulator fed by d[(5*j+3) mod FRAME_LEN].
- R4: Branch 3 is a feed-forward encoder fed by u[j] = d[(13*j+7) mod FRAME_LEN]. Its output is u[j] XOR u[j-1], with u[-1] = 0.
- R5: Branch 4 is an accumulator fed by d[(9*j+11) mod FRAME_LEN].
- R6: Each frame produces exactly FRAME_LEN output beats, one per information bit j. For even j, `out_pair[0]` carries the branch 1 bit and `out_pair[1]` the branch 2 bit. For odd j, `out_pair[0]` carries the branch 3 bit and `out_pair[1]` the branch 4 bit.
- R7: Every encoder state is zero at the start of each frame. Nothing carries over from the previous frame, and no termination bits are added.
- R8: The first beat of a frame appears two clock edges after the edge that accepts its last input bit. The remaining beats follow on consecutive cycles with no gap.
- R9: `out_eof` is 1 on the last beat of each frame and only there.
- R10: A valid bit without `in_sof` while no frame is open is ignored. An `in_sof` in the middle of a frame discards the partial frame and starts a new one with that bit as index 0.
- R11: Cycles with `in_valid` low are skipped, so frames may arrive with gaps. A new frame may start on the cycle right after the previous frame's last bit.
- R12: `out_pair` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit strobe |
| in_sof | input | 1 | First bit of a frame (qualified by in_valid) |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Punctured parity pair valid |
| out_pair | output | 2 | Punctured parity bits for one information bit |
| out_eof | output | 1 | Marks the last pair of a frame |

## Verification
The hardest situations to reach are two input events that arrive while an earlier frame is still being read out. One is the write bank switching under a back-to-back frame. The other is an in_sof restart or stray valid bits landing while the read side is busy. The stimulus covers these cases in four ways:
- It sends frames with no idle cycle between them, so collection of frame k+1 overlaps readout of frame k.
- It aborts a partial frame with a fresh in_sof.
- It drives bits without a frame-start both right after a frame completes and while the bank is idle.
- It adds random gaps in the valid strobe.

The scoreboard expects beats only from complete frames, each at an exact cycle. Any extra or shifted beat therefore shows up as a failure.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  localparam int NUM_BR = 4;

  typedef enum logic {
    KIND_ACC = 1'b0,
    KIND_FF  = 1'b1
  } kind_e;

  // branch 3 (index 2) is the feed-forward constituent
  function automatic kind_e br_kind(input int b);
    return (b == 2) ? KIND_FF : KIND_ACC;
  endfunction

  // permutation address = (mult*j + offs) mod FRAME_LEN, odd mult => bijection
  function automatic int unsigned il_mult(input int b);
    case (b)
      0:       return 1;
      1:       return 5;
      2:       return 13;
      default: return 9;
    endcase
  endfunction

  function automatic int unsigned il_offs(input int b);
    case (b)
      0:       return 0;
      1:       return 3;
      2:       return 7;
      default: return 11;
    endcase
  endfunction

endpackage

// File: rtl/mtc_il_table.sv
module mtc_il_table #(
  parameter int FRAME_LEN = 16,
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic [AW-1:0]                     idx,
  output logic [mtc_pkg::NUM_BR-1:0][AW-1:0] addr
);
  for (genvar b = 0; b < mtc_pkg::NUM_BR; b++) begin : g_br
    localparam int unsigned MUL = mtc_pkg::il_mult(b);
    localparam int unsigned OFS = mtc_pkg::il_offs(b);
    logic [31:0] lin;
    always_comb begin
      lin     = MUL * 32'(idx) + OFS;
      addr[b] = lin[AW-1:0];
    end
  end
endmodule

// File: rtl/mtc_bitram.sv
module mtc_bitram #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtc_constituent.sv
module mtc_constituent #(
  parameter mtc_pkg::kind_e KIND = mtc_pkg::KIND_ACC
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic first,
  input  logic din,
  output logic pnext
);
  logic st;
  logic st_eff;

  always_comb begin
    st_eff = first ? 1'b0 : st;
    pnext  = din ^ st_eff;
  end

  if (KIND == mtc_pkg::KIND_ACC) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)     st <= 1'b0;
      else if (en) st <= pnext;
    end
  end else begin : g_ff
    always_ff @(posedge clk) begin
      if (rst)     st <= 1'b0;
      else if (en) st <= din;
    end
  end
endmodule

// File: rtl/mtc_encoder.sv
module mtc_encoder #(
  parameter int FRAME_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_bit,
  output logic       out_valid,
  output logic [1:0] out_pair,
  output logic       out_eof
);
  localparam int AW   = $clog2(FRAME_LEN);
  localparam int RAW  = AW + 1;
  localparam int NBR  = mtc_pkg::NUM_BR;
  localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);

  // ---------------- collection side ----------------
  logic          wr_open, wr_bank;
  logic [AW-1:0] wr_idx, widx_eff;
  logic          accept, last_wr;

  always_comb begin
    accept   = in_valid && (in_sof || wr_open);
    widx_eff = in_sof ? '0 : wr_idx;
    last_wr  = accept && (widx_eff == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_open <= 1'b0;
      wr_idx  <= '0;
      wr_bank <= 1'b0;
    end else if (accept) begin
      if (last_wr) begin
        wr_open <= 1'b0;
        wr_idx  <= '0;
        wr_bank <= ~wr_bank;
      end else begin
        wr_open <= 1'b1;
        wr_idx  <= widx_eff + 1'b1;
      end
    end
  end

  // ---------------- readout side ----------------
  logic          rd_active, rd_bank;
  logic [AW-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      rd_idx    <= '0;
      rd_bank   <= 1'b0;
    end else if (last_wr) begin
      rd_active <= 1'b1;
      rd_idx    <= '0;
      rd_bank   <= wr_bank;
    end else if (rd_active) begin
      if (rd_idx == LAST_IDX) rd_active <= 1'b0;
      else                    rd_idx    <= rd_idx + 1'b1;
    end
  end

  logic [NBR-1:0][AW-1:0] il_addr;

  mtc_il_table #(.FRAME_LEN(FRAME_LEN)) il_i (
    .idx  (rd_idx),
    .addr (il_addr)
  );

  // one frame-store copy per branch so each gets its own read port
  logic [NBR-1:0] ram_q;
  logic [NBR-1:0] pnext;
  logic           s1_valid, s1_first, s1_odd, s1_last;

  for (genvar b = 0; b < NBR; b++) begin : g_branch
    mtc_bitram #(.DEPTH(2 * FRAME_LEN)) ram_i (
      .clk   (clk),
      .we    (accept),
      .waddr ({wr_bank, widx_eff}),
      .wdata (in_bit),
      .raddr ({rd_bank, il_addr[b]}),
      .rdata (ram_q[b])
    );

    mtc_constituent #(.KIND(mtc_pkg::br_kind(b))) enc_i (
      .clk   (clk),
      .rst   (rst),
      .en    (s1_valid),
      .first (s1_first),
      .din   (ram_q[b]),
      .pnext (pnext[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_odd   <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= rd_active;
      s1_first <= rd_active && (rd_idx == '0);
      s1_odd   <= rd_idx[0];
      s1_last  <= rd_active && (rd_idx == LAST_IDX);
    end
  end

  // ---------------- puncture and register ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
      out_pair  <= '0;
    end else begin
      out_valid <= s1_valid;
      out_eof   <= s1_last;
      if (!s1_valid)   out_pair <= '0;
      else if (s1_odd) out_pair <= {pnext[3], pnext[2]};
      else             out_pair <= {pnext[1], pnext[0]};
    end
  end

endmodule

// File: rtl/mtc_encoder_chk.sv
module mtc_encoder_chk #(
  parameter int FRAME_LEN = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic [1:0] out_pair,
  input logic       out_eof
);
  localparam int CW = $clog2(FRAME_LEN) + 1;
  logic [CW-1:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 beat_cnt <= '0;
    else if (out_eof)        beat_cnt <= '0;
    else if (out_valid)      beat_cnt <= beat_cnt + 1'b1;
  end

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && !out_eof && out_pair == 2'b00)); // R1
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (rst) out_eof |-> (beat_cnt == CW'(FRAME_LEN - 1))); // R6
  AST_NO_GAP: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_eof) |=> out_valid); // R8
  AST_EOF_IN_BEAT: assert property (@(posedge clk) disable iff (rst) out_eof |-> out_valid); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !out_valid |-> (out_pair == 2'b00)); // R12
endmodule

bind mtc_encoder mtc_encoder_chk #(.FRAME_LEN(FRAME_LEN)) chk_i (.*);

// File: tb/mtc_encoder_tb_top.sv
module mtc_encoder_tb_top;
  localparam int FL = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_valid;
  logic [1:0] out_pair;
  logic       out_eof;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0]  pair;
    logic        eof;
    int unsigned when;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mtc_encoder #(.FRAME_LEN(FL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_bit(in_bit), .out_valid(out_valid), .out_pair(out_pair), .out_eof(out_eof)
  );

  // expected model: R2 R3 R4 R5 R6 R7 R8 R9
  task automatic push_expect(input logic [FL-1:0] d, input int unsigned first_cyc);
    logic a1, a2, f3p, a4, y3, u1, u2, u3, u4;
    exp_t e;
    a1 = 0; a2 = 0; f3p = 0; a4 = 0;
    for (int j = 0; j < FL; j++) begin
      u1 = d[j];
      u2 = d[(5 * j + 3) % FL];
      u3 = d[(13 * j + 7) % FL];
      u4 = d[(9 * j + 11) % FL];
      a1 = u1 ^ a1;
      a2 = u2 ^ a2;
      y3 = u3 ^ f3p;
      f3p = u3;
      a4 = u4 ^ a4;
      e.pair = (j % 2 == 0) ? {a2, a1} : {a4, y3};
      e.eof  = (j == FL - 1);
      e.when = first_cyc + j;
      sb_q.push_back(e);
    end
  endtask

  task automatic send_frame(input logic [FL-1:0] d, input bit gaps);
    for (int i = 0; i < FL; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_bit   = d[i];
      if (i == FL - 1) push_expect(d, cyc + 3);
      if (gaps && i != FL - 1 && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
    end
  endtask

  task automatic stray_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_bit   = 1'b1;
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        n_chk++;
        if (sb_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected beat pair=%b eof=%b at cycle %0d, expected none", out_pair, out_eof, cyc);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          if (out_pair !== e.pair || out_eof !== e.eof || cyc != e.when) begin
            n_fail++;
            $display("FAIL R2-model/R6/R8/R9: pair=%b eof=%b cyc=%0d, expected pair=%b eof=%b cyc=%0d",
                     out_pair, out_eof, cyc, e.pair, e.eof, e.when);
          end
        end
      end else begin
        if (out_pair !== 2'b00 || out_eof !== 1'b0) begin
          n_chk++;
          n_fail++;
          $display("FAIL R12: idle pair=%b eof=%b, expected 00 0", out_pair, out_eof);
        end
        if (sb_q.size() != 0 && cyc > sb_q[0].when) begin
          n_chk++;
          n_fail++;
          $display("FAIL R8: beat missing at cycle %0d, expected at %0d", cyc, sb_q[0].when);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (out_valid !== 1'b0 || out_pair !== 2'b00 || out_eof !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: out=%b%b%b, expected 000", out_valid, out_pair, out_eof);
    end
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%b after release, expected 0", out_valid);
    end

    // R10: stray bits with no open frame produce nothing
    stray_bits(5);
    idle(6);

    // R2 R3 R4 R5 R6: single-one frame exposes the permutations
    send_frame(16'h0001, 1'b0);
    idle(FL + 6);
    send_frame(16'h8000, 1'b0);
    idle(FL + 6);
    // all zeros and all ones
    send_frame(16'h0000, 1'b0);
    idle(FL + 6);
    send_frame(16'hFFFF, 1'b0);
    // R7 R11: back-to-back frames, state must restart at each frame
    send_frame(16'hA5C3, 1'b0);
    send_frame(16'h3C5A, 1'b0);
    send_frame(16'hFFFF, 1'b0);
    // R10: stray bits during readout are ignored
    stray_bits(4);
    idle(FL + 6);

    // R10: aborted partial frame then restart
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_bit   = 1'b1;
    end
    send_frame(16'h1234, 1'b0);
    idle(FL + 6);

    // R11: frames with gaps in the valid strobe
    for (int k = 0; k < 8; k++) begin
      send_frame(16'($urandom), 1'b1);
      if (k % 2 == 1) idle(3);
    end
    for (int k = 0; k < 6; k++) send_frame(16'($urandom), 1'b0);
    idle(FL + 10);

    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R6: %0d beats never produced, expected 0", sb_q.size());
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule